// File: doc/BRIEF.md
# Cascadable BCD Down-Counter Digit

A single decimal digit that counts down from 9 to 0, one step per clock edge on which the step enable is high. Several of these digits are chained to build a multi-digit countdown: the least significant digit is stepped by the time base. Each higher digit is stepped when the digit below it reaches zero. The carry input of a digit decides what happens when it is stepped at zero. It either wraps to 9, borrowing from the digit above, or stays at 0 once every higher digit is already exhausted.

Two status outputs serve the chain. The first is a borrow-style clock output that sits low while the digit is zero, so its falling edge marks the step for the next digit. The second is a nonzero flag that goes high while any count bit is set, so a chain can combine the flags to detect that the whole countdown is finished. A synchronous load presets the digit and takes priority over stepping. A digit that holds an illegal code (10 to 15), for example from its reset value, falls back to 9 on its next step.

Top module: `bcd_down_digit`

## Requirements
- R1: While rst_ni is low, count_o is set to the RESET_CODE parameter (default 0). With the default, clk_out_o and carry_out_o are both low after reset.
- R2: When step_i is high and load_i is low, a count of 1 to 9 becomes count minus one after the next rising clk_i edge.
- R3: When step_i is high, load_i is low and carry_i is high, a count of 0 becomes 9 after the edge.
- R4: When step_i is high, load_i is low and carry_i is low, a count of 0 stays 0.
- R5: When step_i and load_i are both low, the count holds its value (legal or illegal) whatever carry_i and load_val_i do.
- R6: When load_i is high, count_o takes load_val_i after the edge, regardless of step_i and carry_i.
- R7: A load value of 10 to 15 is stored as 9.
- R8: clk_out_o is low exactly when all four bits of count_o are 0, and high otherwise. Its falling edge is the step for the next higher digit.
- R9: carry_out_o is high exactly when at least one bit of count_o is 1.
- R10: When step_i is high and load_i is low, an illegal count of 10 to 15 becomes 9 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low, loads RESET_CODE |
| step_i | input | 1 | Decrement enable for this edge |
| carry_i | input | 1 | Permits the wrap from 0 to 9 |
| load_i | input | 1 | Synchronous preset, overrides step_i |
| load_val_i | input | 4 | Preset value, saturated to 9 |
| count_o | output | 4 | Current BCD digit |
| clk_out_o | output | 1 | Low while the digit is zero; falling edge steps the next digit |
| carry_out_o | output | 1 | High while the digit is nonzero |

## Verification
The hardest state to reach is an illegal code. Loads saturate and stepping never produces one, so the ports alone cannot leave the legal range after reset. The bench therefore adds a second instance whose RESET_CODE parameter is 15. It holds that instance idle to show the illegal code persists, then steps it once to confirm the fall back to 9. The main instance gets random steps, carries and occasional loads with out-of-range values. Directed runs through zero with carry_i held low and then high cover both zero behaviours.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned DIGIT_MAX = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t TOP_CODE = digit_t'(DIGIT_MAX);
endpackage

// File: rtl/bcd_next_sel.sv
module bcd_next_sel
  import bcd_digit_pkg::*;
(
  input  digit_t cur_i,
  input  logic   step_i,
  input  logic   carry_i,
  input  logic   load_i,
  input  digit_t load_val_i,
  output digit_t nxt_o
);
  digit_t load_sat;
  digit_t dec_val;

  assign load_sat = (load_val_i > TOP_CODE) ? TOP_CODE : load_val_i;

  always_comb begin
    if (cur_i > TOP_CODE)       dec_val = TOP_CODE;   // illegal code recovery
    else if (cur_i == '0)       dec_val = carry_i ? TOP_CODE : '0;
    else                        dec_val = cur_i - digit_t'(1);
  end

  always_comb begin
    if (load_i)      nxt_o = load_sat;
    else if (step_i) nxt_o = dec_val;
    else             nxt_o = cur_i;
  end
endmodule

// File: rtl/bcd_flags.sv
module bcd_flags
  import bcd_digit_pkg::*;
(
  input  digit_t cnt_i,
  output logic   zero_n_o,
  output logic   any_o
);
  logic [DIGIT_W:0] acc;
  assign acc[0] = 1'b0;
  for (genvar b = 0; b < DIGIT_W; b++) begin : g_or
    assign acc[b+1] = acc[b] | cnt_i[b];
  end
  assign zero_n_o = acc[DIGIT_W];
  assign any_o    = acc[DIGIT_W];
endmodule

// File: rtl/bcd_down_digit.sv
module bcd_down_digit
  import bcd_digit_pkg::*;
#(
  parameter logic [3:0] RESET_CODE = 4'd0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       carry_i,
  input  logic       load_i,
  input  logic [3:0] load_val_i,
  output logic [3:0] count_o,
  output logic       clk_out_o,
  output logic       carry_out_o
);
  digit_t cnt_q, cnt_d;

  bcd_next_sel i_next (
    .cur_i      (cnt_q),
    .step_i     (step_i),
    .carry_i    (carry_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .nxt_o      (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RESET_CODE;
    else         cnt_q <= cnt_d;
  end

  bcd_flags i_flags (
    .cnt_i    (cnt_q),
    .zero_n_o (clk_out_o),
    .any_o    (carry_out_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/bcd_down_digit_chk.sv
module bcd_down_digit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       step_i,
  input logic       carry_i,
  input logic       load_i,
  input logic [3:0] load_val_i,
  input logic [3:0] count_o,
  input logic       clk_out_o,
  input logic       carry_out_o
);
  // R2
  dec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && count_o >= 4'd1 && count_o <= 4'd9)
      |=> count_o == $past(count_o) - 4'd1);
  // R3
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && carry_i && count_o == 4'd0) |=> count_o == 4'd9);
  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !carry_i && count_o == 4'd0) |=> count_o == 4'd0);
  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(count_o));
  // R6
  load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i <= 4'd9) |=> count_o == $past(load_val_i));
  // R7
  load_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i > 4'd9) |=> count_o == 4'd9);
  // R8
  clk_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_out_o == (count_o != 4'd0));
  // R9
  nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_out_o == (count_o != 4'd0));
  // R10
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && count_o > 4'd9) |=> count_o == 4'd9);
endmodule

bind bcd_down_digit bcd_down_digit_chk i_bcd_down_digit_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .step_i      (step_i),
  .carry_i     (carry_i),
  .load_i      (load_i),
  .load_val_i  (load_val_i),
  .count_o     (count_o),
  .clk_out_o   (clk_out_o),
  .carry_out_o (carry_out_o)
);

// File: tb/test_bcd_down_digit.sv
`timescale 1ns/1ps
module test_bcd_down_digit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0, carry = 1'b0, load = 1'b0;
  logic [3:0] load_val = 4'd0;
  logic [3:0] count;
  logic       clk_out, carry_out;
  logic       ill_step = 1'b0;
  logic [3:0] ill_count;
  logic       ill_clk_out, ill_carry_out;
  int         checks = 0, failures = 0;
  logic [3:0] exp_cnt;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  bcd_down_digit i_bcd_down_digit (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .carry_i(carry),
    .load_i(load), .load_val_i(load_val), .count_o(count),
    .clk_out_o(clk_out), .carry_out_o(carry_out)
  );

  bcd_down_digit #(.RESET_CODE(4'd15)) i_bcd_down_digit_ill (
    .clk_i(clk), .rst_ni(rst_n), .step_i(ill_step), .carry_i(1'b0),
    .load_i(1'b0), .load_val_i(4'd0), .count_o(ill_count),
    .clk_out_o(ill_clk_out), .carry_out_o(ill_carry_out)
  );

  function automatic logic [3:0] model_next(logic [3:0] cur, logic st, logic cy,
                                            logic ld, logic [3:0] lv);
    if (ld)            return (lv > 4'd9) ? 4'd9 : lv;
    if (!st)           return cur;
    if (cur > 4'd9)    return 4'd9;
    if (cur == 4'd0)   return cy ? 4'd9 : 4'd0;
    return cur - 4'd1;
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_flags(string tag);
    check({"R8 ", tag}, {3'd0, clk_out},   {3'd0, exp_cnt != 4'd0});
    check({"R9 ", tag}, {3'd0, carry_out}, {3'd0, exp_cnt != 4'd0});
  endtask

  // drive at negedge, edge, sample 1 ns later
  task automatic cyc(logic st, logic cy, logic ld, logic [3:0] lv, string req);
    @(negedge clk);
    step = st; carry = cy; load = ld; load_val = lv;
    exp_cnt = model_next(exp_cnt, st, cy, ld, lv);
    @(posedge clk); #1;
    check(req, count, exp_cnt);
    check_flags(req);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    exp_cnt = 4'd0;
    #23;
    // R1 reset state
    check("R1 count", count, 4'd0);
    check("R1 clk_out", {3'd0, clk_out}, 4'd0);
    check("R1 carry_out", {3'd0, carry_out}, 4'd0);
    check("R1 illegal reset", ill_count, 4'd15);
    @(negedge clk); rst_n = 1'b1;

    // R4 no wrap at zero
    cyc(1'b1, 1'b0, 1'b0, 4'd0, "R4");
    cyc(1'b1, 1'b0, 1'b0, 4'd0, "R4");
    // R3 wrap at zero
    cyc(1'b1, 1'b1, 1'b0, 4'd0, "R3");
    // R2 full walk down 9..0
    for (int k = 0; k < 9; k++) cyc(1'b1, 1'b0, 1'b0, 4'd0, "R2");
    // R5 hold with noisy carry and load value
    cyc(1'b0, 1'b1, 1'b0, 4'd7, "R5");
    // R6 load overrides step
    cyc(1'b1, 1'b1, 1'b1, 4'd5, "R6");
    // R7 saturating loads
    cyc(1'b0, 1'b0, 1'b1, 4'd12, "R7");
    cyc(1'b1, 1'b0, 1'b1, 4'd15, "R7");
    cyc(1'b0, 1'b0, 1'b1, 4'd1, "R6");
    // R8 falling edge into zero
    cyc(1'b1, 1'b0, 1'b0, 4'd0, "R8 fall");

    // R10 illegal code: holds idle (R5), recovers to 9 on step
    @(negedge clk); ill_step = 1'b0;
    @(posedge clk); #1;
    check("R5 illegal hold", ill_count, 4'd15);
    check("R9 illegal nonzero", {3'd0, ill_carry_out}, 4'd1);
    check("R8 illegal clk_out", {3'd0, ill_clk_out}, 4'd1);
    @(negedge clk); ill_step = 1'b1;
    @(posedge clk); #1;
    check("R10 recover", ill_count, 4'd9);
    @(negedge clk); ill_step = 1'b0;

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic st, cy, ld;
      logic [3:0] lv;
      st = ($urandom % 4) != 0;
      cy = $urandom % 2;
      ld = ($urandom % 12) == 0;
      lv = 4'($urandom % 16);
      cyc(st, cy, ld, lv, "R2/R3/R4/R5/R6/R7 random");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule